// File: doc/BRIEF.md
# Interrupt Source Group Register Block

This block holds the interrupt state for one group of up to 32 event sources. It has four registers on a small register bus. The live-level register shows the raw event inputs. The block register decides which events may be recorded at all. The latched register records each allowed event until software acknowledges it. The gate register decides which latched events count toward the group's pending output. Software acknowledges an event by writing a one to its bit in the latched register.

The single-bit pending output is high when any latched bit is also gated on. An upstream aggregator consumes this output. The block also gives that aggregator two one-cycle hints:
- `upd_pulse` means the group's upstream contribution may have changed, so it must be recomputed.
- `chk_pulse` means pending interrupts must be looked at again before an interrupt is delivered.

Blocking acts when an event is latched, and gating acts on the pending output. Because of this split, a blocked event is lost for good. A latched event whose gate is off stays recorded, and it raises the pending output as soon as its gate is opened.

Top module: `irq_group`

## Requirements
- R1: After reset, all stored registers read 0, `irq_pending` is 0, and both pulse outputs are 0.
- R2: A read at offset 0x0 returns the current `evt_in` levels combinationally. A write to offset 0x0 changes no register and raises no pulse.
- R3: A high `evt_in` bit sets the matching latched-register bit (offset 0x8) at the next clock edge, but only when the block-register bit (offset 0x4) is 0 at that edge. A blocked event is dropped. A block-register write and an event in the same cycle use the old block value.
- R4: A write to offset 0x8 clears each latched bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to offset 0x4 replaces the whole block register, which reads back at 0x4. `chk_pulse` is high for exactly the one cycle after the write edge, and `upd_pulse` stays low.
- R6: A write to offset 0xC replaces the whole gate register, which reads back at 0xC. Both `upd_pulse` and `chk_pulse` are high for exactly the one cycle after the write edge.
- R7: A write to offset 0x8 raises `upd_pulse`, and not `chk_pulse`, for exactly the one cycle after the write edge.
- R8: `irq_pending` equals the OR over all bits of (latched AND gate). A bit latched while its gate is 0 raises `irq_pending` once the gate is written to 1.
- R9: When an allowed event and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R10: A write to any offset other than 0x0, 0x4, 0x8 or 0xC, including unaligned ones, changes nothing and raises no pulse. A read at such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 32 | Event inputs, sampled on each clock edge |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset within the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| irq_pending | output | 1 | OR of latched and gated bits |
| upd_pulse | output | 1 | One-cycle request to recompute the upstream contribution |
| chk_pulse | output | 1 | One-cycle request to re-check pending interrupts |

## Verification
Two things can land on the same clock edge:
- An event arriving and software writing the latched register. The bench drives an allowed event and a write-one-to-clear of that same bit in one cycle, then reads the latched register to confirm the bit survived.
- An event arriving and a block-register update. The vector table writes an all-ones block value in the same cycle as a new event that the old block value allowed. The later readback and the pending output confirm that the old value decided the latch.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

    localparam int unsigned OFS_LIVE  = 32'h0;
    localparam int unsigned OFS_BLOCK = 32'h4;
    localparam int unsigned OFS_LATCH = 32'h8;
    localparam int unsigned OFS_GATE  = 32'hC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LIVE,
        SEL_BLOCK,
        SEL_LATCH,
        SEL_GATE
    } reg_sel_e;

    typedef struct packed {
        logic block;
        logic latch;
        logic gate;
    } wr_stb_t;

    function automatic reg_sel_e ofs_to_sel(input int unsigned ofs);
        case (ofs)
            OFS_LIVE:  return SEL_LIVE;
            OFS_BLOCK: return SEL_BLOCK;
            OFS_LATCH: return SEL_LATCH;
            OFS_GATE:  return SEL_GATE;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_group_decode.sv
module irq_group_decode
    import irq_group_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  live,
    input  logic [W-1:0]  block_q,
    input  logic [W-1:0]  latch_q,
    input  logic [W-1:0]  gate_q,
    output wr_stb_t       stb,
    output logic [W-1:0]  rdata
);
    reg_sel_e sel;

    always_comb begin
        sel       = ofs_to_sel(32'(bus_addr));
        stb.block = bus_wr && (sel == SEL_BLOCK);
        stb.latch = bus_wr && (sel == SEL_LATCH);
        stb.gate  = bus_wr && (sel == SEL_GATE);
        case (sel)
            SEL_LIVE:  rdata = live;
            SEL_BLOCK: rdata = block_q;
            SEL_LATCH: rdata = latch_q;
            SEL_GATE:  rdata = gate_q;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        a_one_strobe_r10: assert ($countones(stb) <= 1)
            else $error("more than one write strobe");
    end
endmodule

// File: rtl/irq_group_latch.sv
module irq_group_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] block_q,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] latch_q
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] allowed;

    assign clr_vec = clr_stb ? clr_data : '0;
    assign allowed = evt & ~block_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                latch_q[g] <= 1'b0;
            else if (allowed[g])
                latch_q[g] <= 1'b1;
            else if (clr_vec[g])
                latch_q[g] <= 1'b0;
        end
    end

    p_blocked_dropped_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & ~$past(latch_q) & $past(block_q)) == '0));

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(clr_vec) & ~$past(allowed)) == '0));

    p_only_clear_falls_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~latch_q & $past(latch_q) & ~$past(clr_vec)) == '0));

    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(allowed) & ~latch_q) == '0));
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import irq_group_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_stb_t      stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] latch_q,
    output logic [W-1:0] block_q,
    output logic [W-1:0] gate_q,
    output logic         pending,
    output logic         upd_pulse,
    output logic         chk_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            block_q   <= '0;
            gate_q    <= '0;
            upd_pulse <= 1'b0;
            chk_pulse <= 1'b0;
        end else begin
            if (stb.block) block_q <= wdata;
            if (stb.gate)  gate_q  <= wdata;
            upd_pulse <= stb.gate | stb.latch;
            chk_pulse <= stb.gate | stb.block;
        end
    end

    assign pending = |(latch_q & gate_q);

    p_block_chk_r5: assert property (@(posedge clk) disable iff (rst)
        stb.block |=> (chk_pulse && !upd_pulse && block_q == $past(wdata)));

    p_gate_both_r6: assert property (@(posedge clk) disable iff (rst)
        stb.gate |=> (chk_pulse && upd_pulse && gate_q == $past(wdata)));

    p_latch_upd_r7: assert property (@(posedge clk) disable iff (rst)
        stb.latch |=> (upd_pulse && !chk_pulse));

    p_quiet_no_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (stb == '0) |=> (!upd_pulse && !chk_pulse));
endmodule

// File: rtl/irq_group.sv
module irq_group
    import irq_group_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  evt_in,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          irq_pending,
    output logic          upd_pulse,
    output logic          chk_pulse
);
    wr_stb_t      stb;
    logic [W-1:0] block_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] gate_q;

    irq_group_decode #(.W(W), .AW(AW)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .live     (evt_in),
        .block_q  (block_q),
        .latch_q  (latch_q),
        .gate_q   (gate_q),
        .stb      (stb),
        .rdata    (bus_rdata)
    );

    irq_group_latch #(.W(W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_in),
        .block_q  (block_q),
        .clr_stb  (stb.latch),
        .clr_data (bus_wdata),
        .latch_q  (latch_q)
    );

    irq_group_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb),
        .wdata     (bus_wdata),
        .latch_q   (latch_q),
        .block_q   (block_q),
        .gate_q    (gate_q),
        .pending   (irq_pending),
        .upd_pulse (upd_pulse),
        .chk_pulse (chk_pulse)
    );

    p_live_read_r2: assert property (@(posedge clk) disable iff (rst)
        (32'(bus_addr) == OFS_LIVE) |-> (bus_rdata == evt_in));

    p_stray_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && stb == '0) |=> ($stable(block_q) && $stable(gate_q)
                                   && !upd_pulse && !chk_pulse));

    p_stray_read_r10: assert property (@(posedge clk) disable iff (rst)
        (ofs_to_sel(32'(bus_addr)) == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_group.sv
module tb_irq_group;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] evt;
        logic [31:0] exp_rd;
        logic        exp_pend;
    } vec_t;

    // Starts from reset; block and gate both zero.
    localparam vec_t VECS [0:8] = '{
        '{1'b1, 8'h04, 32'h0000_00F0, 32'h0,          32'h0000_00F0, 1'b0}, // R5
        '{1'b0, 8'h08, 32'h0,          32'h0000_00FF, 32'h0000_000F, 1'b0}, // R3
        '{1'b1, 8'h0C, 32'h0000_0003, 32'h0,          32'h0000_0003, 1'b1}, // R6 R8
        '{1'b1, 8'h08, 32'h0000_0001, 32'h0,          32'h0000_000E, 1'b1}, // R4
        '{1'b1, 8'h08, 32'h0000_0002, 32'h0,          32'h0000_000C, 1'b0}, // R4 R8
        '{1'b1, 8'h0C, 32'h0000_0004, 32'h0,          32'h0000_0004, 1'b1}, // R8
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h1000_0000, 32'hFFFF_FFFF, 1'b1}, // R3 old block
        '{1'b0, 8'h08, 32'h0,          32'h0000_0001, 32'h1000_000C, 1'b1}, // R3 blocked
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,          32'h0000_0000, 1'b0}  // R4
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pending, upd_pulse, chk_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_group dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pending(irq_pending), .upd_pulse(upd_pulse), .chk_pulse(chk_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; evt_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // Drive one cycle of stimulus, then sample after the edge, with bus idle.
    task automatic apply(input logic wr, input logic [7:0] a,
                         input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = e;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        #1;
    endtask

    function automatic logic [31:0] rd(input logic [7:0] a);
        return 32'(0);
    endfunction

    task automatic read_at(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        foreach (VECS[i]) begin end
        read_at(8'h04, v); check("R1 block", v, 32'h0);
        read_at(8'h08, v); check("R1 latch", v, 32'h0);
        read_at(8'h0C, v); check("R1 gate", v, 32'h0);
        check("R1 pending", 32'(irq_pending), 32'h0);
        check("R1 pulses", {30'h0, upd_pulse, chk_pulse}, 32'h0);

        // Table walk
        for (int i = 0; i < 9; i++) begin
            apply(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].evt);
            read_at(VECS[i].addr, v);
            check($sformatf("R3-R8 vec%0d rd", i), v, VECS[i].exp_rd);
            check($sformatf("R8 vec%0d pend", i), 32'(irq_pending), 32'(VECS[i].exp_pend));
        end

        do_reset();

        // R2 live read, no latching when sampled before the edge
        @(negedge clk);
        bus_addr = 8'h00; evt_in = 32'h0000_00A5;
        #1; check("R2 live", bus_rdata, 32'h0000_00A5);
        evt_in = '0;
        #1; check("R2 live follows", bus_rdata, 32'h0);

        // R2 write to live offset ignored
        apply(1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0);
        check("R2 no pulse", {30'h0, upd_pulse, chk_pulse}, 32'h0);
        read_at(8'h04, v); check("R2 block kept", v, 32'h0);
        read_at(8'h0C, v); check("R2 gate kept", v, 32'h0);

        // R10 stray offsets
        apply(1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0);
        check("R10 no pulse hi", {30'h0, upd_pulse, chk_pulse}, 32'h0);
        read_at(8'h10, v); check("R10 read zero", v, 32'h0);
        apply(1'b1, 8'h06, 32'hFFFF_FFFF, 32'h0);
        check("R10 no pulse unaligned", {30'h0, upd_pulse, chk_pulse}, 32'h0);
        read_at(8'h06, v); check("R10 unaligned read zero", v, 32'h0);
        read_at(8'h04, v); check("R10 block kept", v, 32'h0);
        read_at(8'h0C, v); check("R10 gate kept", v, 32'h0);

        // R5 block write pulses
        apply(1'b1, 8'h04, 32'h0000_000F, 32'h0);
        check("R5 chk high", 32'(chk_pulse), 32'h1);
        check("R5 upd low", 32'(upd_pulse), 32'h0);
        apply(1'b0, 8'h04, 32'h0, 32'h0);
        check("R5 chk single", 32'(chk_pulse), 32'h0);

        // R3 blocked low nibble
        apply(1'b0, 8'h08, 32'h0, 32'h0000_00FF);
        read_at(8'h08, v); check("R3 latch", v, 32'h0000_00F0);
        check("R8 gated off", 32'(irq_pending), 32'h0);

        // R7 latch write pulses
        apply(1'b1, 8'h08, 32'h0000_0010, 32'h0);
        check("R7 upd high", 32'(upd_pulse), 32'h1);
        check("R7 chk low", 32'(chk_pulse), 32'h0);
        read_at(8'h08, v); check("R4 cleared", v, 32'h0000_00E0);
        apply(1'b0, 8'h08, 32'h0, 32'h0);
        check("R7 upd single", 32'(upd_pulse), 32'h0);

        // R9 event wins over clear
        apply(1'b1, 8'h08, 32'h0000_0020, 32'h0000_0020);
        read_at(8'h08, v); check("R9 event wins", v, 32'h0000_00E0);

        // R6 / R8 late enable fires latched bit
        apply(1'b1, 8'h0C, 32'h0000_0080, 32'h0);
        check("R6 both pulses", {30'h0, upd_pulse, chk_pulse}, 32'h3);
        check("R8 late enable", 32'(irq_pending), 32'h1);
        apply(1'b0, 8'h0C, 32'h0, 32'h0);
        check("R6 pulses single", {30'h0, upd_pulse, chk_pulse}, 32'h0);
        apply(1'b1, 8'h08, 32'h0000_0080, 32'h0);
        check("R8 cleared drops", 32'(irq_pending), 32'h0);
        read_at(8'h08, v); check("R4 partial clear", v, 32'h0000_0060);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule